// File: doc/BRIEF.md
# Dual-Issue Pair Hazard Checker

This block makes the issue decision for a two-wide, in-order, statically scheduled pipeline. Fetch hands it one aligned packet per cycle. The first slot of the packet holds an integer-class instruction and the second slot holds a floating-point operation. Opcode class and register numbers arrive already decoded. Each cycle the block chooses one of three outcomes: both slots issue, only the integer slot issues, or nothing issues. While the current packet has a slot that has not yet left, it asks fetch to hold that packet.

The integer and floating-point register files are separate. The integer slot can therefore interfere with the floating-point slot only through floating-point loads, stores and moves. Such traffic can compete with the floating-point op for the floating-point register ports. It can also produce a value that the op reads in the same packet. In either case the floating-point op is held and then issues alone from the same packet in the next cycle.

Across packets, a load's destination may not be read by any of the three instruction positions that follow the load. These positions are counted in issued instructions, not in cycles. Any stall cycle caused by this rule inserts one bubble, and the bubble counts as one position. Branches in the integer slot are treated like any other integer-file instruction. Their delay-slot positions issue in order and untouched.

Top module: `dual_issue_gate`

## Requirements
- R1: After reset no load-use history remains: the integer slot of the first packet issues whatever registers it reads.
- R2: When the two slots of a packet are independent, both issue in the same cycle and stall_fetch stays low.
- R3: Integer-slot classes are encoded as 0 integer ALU (reads a and b), 1 integer load (reads a, writes integer dst), 2 integer store (reads a and b), 3 branch (reads a and b), 4 floating-point load (reads integer a, writes floating-point dst), 5 floating-point store (reads integer a and floating-point b), 6 move into the floating-point file (reads integer a, writes floating-point dst) and 7 move out of the floating-point file (reads floating-point a, writes integer dst). A valid floating-point op that would issue alongside class 5 or 7 is held, and so is one with fp_wr high alongside class 4 or 6.
- R4: A valid floating-point op is held when it would issue alongside class 4 or 6 and either of its sources equals int_dst, even with fp_wr low.
- R5: A held floating-point op issues alone from the same packet in a later cycle. The integer slot is not issued again, and stall_fetch falls in the cycle the held op issues.
- R6: A source that matches the destination of a load in the same register file, at most three issued positions after that load, does not issue. Each such stall cycle adds one bubble position, so a consumer issues no earlier than the fourth position after the load.
- R7: A slot with its valid bit low never holds the other slot, and its register and class fields have no effect.
- R8: Integer-slot classes 0 to 3, branches included, never hold the floating-point slot, and the packets after a branch issue in order.
- R9: stall_fetch is high exactly when a packet is presented and some valid slot of it has not issued by the end of the cycle. With pkt_valid low all three outputs are low.
- R10: The floating-point slot never issues before the integer slot of the same packet. If the integer slot is stalled, nothing issues that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A packet is presented this cycle |
| int_valid | input | 1 | Integer slot holds a real instruction |
| int_class | input | 3 | Integer-slot class code (see R3) |
| int_dst | input | REG_W | Integer-slot destination register |
| int_src_a | input | REG_W | Integer-slot first source |
| int_src_b | input | REG_W | Integer-slot second source |
| fp_valid | input | 1 | Floating-point slot holds a real operation |
| fp_wr | input | 1 | Floating-point op writes the floating-point file |
| fp_src_a | input | REG_W | Floating-point op first source |
| fp_src_b | input | REG_W | Floating-point op second source |
| issue_int | output | 1 | Integer slot issues this cycle |
| issue_fp | output | 1 | Floating-point slot issues this cycle |
| stall_fetch | output | 1 | Keep presenting the current packet |

## Verification
The assertions take for granted that fetch keeps the same packet on the inputs for as long as stall_fetch is high. This is what makes a hold followed by a lone issue of the floating-point op a meaningful sequence. The bench honours this: in every cycle after a raised stall_fetch it presents the held packet again unchanged, and it draws a new packet only once the previous one has fully retired. Register numbers are kept within 0 to 3 so that pair matches and load-use matches happen often.

// File: rtl/dual_issue_gate.sv
module dual_issue_gate #(
  parameter int REG_W  = 5,
  parameter int LU_WIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic             int_valid,
  input  logic [2:0]       int_class,
  input  logic [REG_W-1:0] int_dst,
  input  logic [REG_W-1:0] int_src_a,
  input  logic [REG_W-1:0] int_src_b,
  input  logic             fp_valid,
  input  logic             fp_wr,
  input  logic [REG_W-1:0] fp_src_a,
  input  logic [REG_W-1:0] fp_src_b,
  output logic             issue_int,
  output logic             issue_fp,
  output logic             stall_fetch
);
  localparam int CW = $clog2(LU_WIN + 1) < 2 ? 2 : $clog2(LU_WIN + 1);
  localparam logic [2:0] C_IALU = 3'd0, C_ILD = 3'd1, C_IST = 3'd2, C_BR  = 3'd3,
                         C_FLD  = 3'd4, C_FST = 3'd5, C_MTF = 3'd6, C_MFF = 3'd7;

  logic             int_done_q;
  logic [CW-1:0]    trk_cnt [LU_WIN];
  logic             trk_fp  [LU_WIN];
  logic [REG_W-1:0] trk_reg [LU_WIN];

  wire a_is_fp   = (int_class == C_MFF);
  wire b_used    = (int_class == C_IALU) || (int_class == C_IST) ||
                   (int_class == C_BR)   || (int_class == C_FST);
  wire b_is_fp   = (int_class == C_FST);
  wire is_load   = (int_class == C_ILD) || (int_class == C_FLD);
  wire wr_fp_int = (int_class == C_FLD) || (int_class == C_MTF);
  wire rd_fp_int = (int_class == C_FST) || (int_class == C_MFF);

  logic hit_int, hit_fp;
  logic int_pend, int_go, int_clear, port_clash, pair_raw, fp_go, pkt_done, bubble;
  logic [CW-1:0] step;

  always_comb begin
    hit_int = 1'b0;
    for (int k = 0; k < LU_WIN; k++) begin
      if (trk_cnt[k] != '0) begin
        if (trk_fp[k] == a_is_fp && trk_reg[k] == int_src_a) hit_int = 1'b1;
        if (b_used && trk_fp[k] == b_is_fp && trk_reg[k] == int_src_b) hit_int = 1'b1;
      end
    end
  end

  assign int_pend  = pkt_valid & int_valid & ~int_done_q;
  assign int_go    = int_pend & ~hit_int;
  assign int_clear = pkt_valid & (~int_valid | int_done_q | int_go);

  always_comb begin
    hit_fp = 1'b0;
    for (int k = 0; k < LU_WIN; k++) begin
      if (trk_fp[k] && trk_cnt[k] > CW'(int_go) &&
          (trk_reg[k] == fp_src_a || trk_reg[k] == fp_src_b)) hit_fp = 1'b1;
    end
  end

  assign port_clash = int_go & fp_valid & (rd_fp_int | (wr_fp_int & fp_wr));
  assign pair_raw   = int_go & fp_valid & wr_fp_int &
                      ((int_dst == fp_src_a) | (int_dst == fp_src_b));
  assign fp_go      = int_clear & fp_valid & ~port_clash & ~pair_raw & ~hit_fp;
  assign pkt_done   = int_clear & (~fp_valid | fp_go);
  assign bubble     = pkt_valid & ~pkt_done & ~int_go & ~fp_go;
  assign step       = CW'(int_go) + CW'(fp_go) + CW'(bubble);

  assign issue_int   = int_go;
  assign issue_fp    = fp_go;
  assign stall_fetch = pkt_valid & ~pkt_done;

  function automatic logic [CW-1:0] cdec(input logic [CW-1:0] c, input logic [CW-1:0] s);
    return (c > s) ? c - s : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_done_q <= 1'b0;
      for (int k = 0; k < LU_WIN; k++) begin
        trk_cnt[k] <= '0;
        trk_fp[k]  <= 1'b0;
        trk_reg[k] <= '0;
      end
    end else begin
      if (pkt_done)    int_done_q <= 1'b0;
      else if (int_go) int_done_q <= 1'b1;
      if (int_go && is_load) begin
        trk_cnt[0] <= CW'(LU_WIN) - CW'(fp_go);
        trk_fp[0]  <= (int_class == C_FLD);
        trk_reg[0] <= int_dst;
        for (int k = 1; k < LU_WIN; k++) begin
          trk_cnt[k] <= cdec(trk_cnt[k-1], step);
          trk_fp[k]  <= trk_fp[k-1];
          trk_reg[k] <= trk_reg[k-1];
        end
      end else begin
        for (int k = 0; k < LU_WIN; k++) trk_cnt[k] <= cdec(trk_cnt[k], step);
      end
    end
  end

  // R10
  fp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fp |-> (issue_int || int_done_q || !int_valid));

  // R3
  port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_int && issue_fp) |-> !((int_class == C_FST) || (int_class == C_MFF) ||
      (((int_class == C_FLD) || (int_class == C_MTF)) && fp_wr)));

  // R4
  pair_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_int && issue_fp && ((int_class == C_FLD) || (int_class == C_MTF)))
      |-> (int_dst != fp_src_a && int_dst != fp_src_b));

  // R5
  held_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_int && stall_fetch) |=> !issue_int);

  // R9
  stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> (!stall_fetch && !issue_int && !issue_fp));

  // R6
  lu_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_fetch && !issue_int && !issue_fp) |-> (hit_int || hit_fp));
endmodule

// File: tb/dual_issue_gate_bench.sv
module dual_issue_gate_bench;
  localparam int RW = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pv, iv, fv, fw;
  logic [2:0] cls;
  logic [RW-1:0] dst, sa, sb, fa, fb;
  logic o_i, o_f, o_s;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dual_issue_gate #(.REG_W(RW), .LU_WIN(3)) u_dual_issue_gate (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pv), .int_valid(iv), .int_class(cls),
    .int_dst(dst), .int_src_a(sa), .int_src_b(sb), .fp_valid(fv), .fp_wr(fw),
    .fp_src_a(fa), .fp_src_b(fb), .issue_int(o_i), .issue_fp(o_f), .stall_fetch(o_s));

  int  m_pos;
  bit  m_done;
  int  lp [3];
  bit  lf [3];
  int  lr [3];
  bit  lv [3];

  function automatic bit blk(int q, bit f, int r);
    for (int k = 0; k < 3; k++)
      if (lv[k] && lf[k] == f && lr[k] == r && q > lp[k] && q - lp[k] <= 3) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_clear();
    m_pos = 0; m_done = 1'b0;
    for (int k = 0; k < 3; k++) begin lv[k] = 1'b0; lp[k] = 0; lf[k] = 1'b0; lr[k] = 0; end
  endtask

  task automatic chk(input bit ei, input bit ef, input bit es, input string tag);
    checks++;
    if (o_i !== ei || o_f !== ef || o_s !== es) begin
      fails++;
      $display("FAIL %s: got int=%0b fp=%0b stall=%0b expected int=%0b fp=%0b stall=%0b",
               tag, o_i, o_f, o_s, ei, ef, es);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pv = 0; iv = 0; fv = 0; fw = 0; cls = 0;
    dst = 0; sa = 0; sb = 0; fa = 0; fb = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic pk(input bit p, input bit i, input int c, input int d, input int a, input int b,
                    input bit f, input bit w, input int x, input int y);
    @(negedge clk);
    pv = p; iv = i; cls = 3'(c); dst = RW'(d); sa = RW'(a); sb = RW'(b);
    fv = f; fw = w; fa = RW'(x); fb = RW'(y);
    #2;
  endtask

  task automatic again(); @(negedge clk); #2; endtask

  bit es_last;
  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got running expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    pk(0,1,0,1,1,2, 1,1,3,4); chk(0,0,0,"R9 idle");
    pk(1,1,0,1,1,2, 1,1,3,4); chk(1,1,0,"R1 first packet");
    pk(1,1,3,0,1,2, 1,1,1,2); chk(1,1,0,"R8 branch pair");
    pk(1,1,0,2,1,2, 1,1,1,2); chk(1,1,0,"R8 delay slot pair");
    pk(1,1,2,0,3,1, 1,0,2,3); chk(1,1,0,"R2 store pair");
    pk(1,1,5,0,1,2, 1,0,1,2); chk(1,0,1,"R3 fp store clash");
    again();                  chk(0,1,0,"R5 lone fp issue");
    pk(1,1,6,7,1,2, 1,1,1,2); chk(1,0,1,"R3 move write clash");
    again();                  chk(0,1,0,"R5 lone fp after move");
    pk(1,1,7,1,2,0, 1,0,3,3); chk(1,0,1,"R3 move out clash");
    again();                  chk(0,1,0,"R5 lone fp after move out");
    pk(1,1,6,7,1,2, 1,0,1,2); chk(1,1,0,"R3 move with non-writing fp op");
    pk(1,0,5,0,1,2, 1,1,1,2); chk(0,1,0,"R7 invalid int slot");
    pk(1,1,5,0,1,2, 0,1,1,2); chk(1,0,0,"R7 invalid fp slot");
    pk(1,0,4,5,1,2, 0,0,5,5); chk(0,0,0,"R7 both invalid");

    do_reset();
    pk(1,1,4,5,1,0, 1,0,5,9); chk(1,0,1,"R4 pair raw");
    again(); chk(0,0,1,"R6 bubble 1");
    again(); chk(0,0,1,"R6 bubble 2");
    again(); chk(0,0,1,"R6 bubble 3");
    again(); chk(0,1,0,"R6 consumer after window");

    do_reset();
    pk(1,1,1,6,1,0, 0,0,0,0); chk(1,0,0,"R6 int load");
    pk(1,1,0,2,6,0, 0,0,0,0); chk(0,0,1,"R6 int use 1");
    again(); chk(0,0,1,"R6 int use 2");
    again(); chk(0,0,1,"R6 int use 3");
    again(); chk(1,0,0,"R6 int use issues");

    do_reset();
    pk(1,1,1,6,1,0, 1,1,1,2); chk(1,1,0,"R6 load with fp pair");
    pk(1,1,0,2,0,6, 0,0,0,0); chk(0,0,1,"R6 window shortened 1");
    again(); chk(0,0,1,"R6 window shortened 2");
    again(); chk(1,0,0,"R6 window shortened issue");

    do_reset();
    pk(1,1,4,3,1,0, 0,0,0,0); chk(1,0,0,"R6 fp load");
    pk(1,1,0,2,3,3, 0,0,0,0); chk(1,0,0,"R6 other file not blocked");

    do_reset();
    pk(1,1,1,6,1,0, 0,0,0,0); chk(1,0,0,"R10 load");
    pk(1,1,0,2,6,0, 1,1,1,2); chk(0,0,1,"R10 int stalled fp waits");
    again(); chk(0,0,1,"R10 still waiting");
    again(); chk(0,0,1,"R10 still waiting 2");
    again(); chk(1,1,0,"R10 pair issues");

    do_reset();
    pk(1,1,4,4,1,0, 0,0,0,0); chk(1,0,0,"R6 fp load 2");
    pk(1,1,0,2,1,2, 1,1,4,1); chk(1,0,1,"R6 fp slot blocked behind int");
    again(); chk(0,0,1,"R6 fp bubble a");
    again(); chk(0,0,1,"R6 fp bubble b");
    again(); chk(0,1,0,"R6 fp consumer issues");

    do_reset();
    es_last = 1'b0;
    for (int n = 0; n < 6000; n++) begin
      bit ip, ei, clr, cf, ef, dn, es, a_fp, b_use, b_fp;
      int q, c;
      @(negedge clk);
      if (!es_last) begin
        pv = ($urandom_range(0, 9) < 8); iv = ($urandom_range(0, 5) != 0);
        cls = 3'($urandom_range(0, 7)); dst = RW'($urandom_range(0, 3));
        sa = RW'($urandom_range(0, 3)); sb = RW'($urandom_range(0, 3));
        fv = ($urandom_range(0, 5) != 0); fw = 1'($urandom_range(0, 1));
        fa = RW'($urandom_range(0, 3)); fb = RW'($urandom_range(0, 3));
      end
      #2;
      c = int'(cls);
      a_fp = (c == 7); b_use = (c == 0 || c == 2 || c == 3 || c == 5); b_fp = (c == 5);
      ip = pv && iv && !m_done;
      ei = ip && !(blk(m_pos + 1, a_fp, int'(sa)) || (b_use && blk(m_pos + 1, b_fp, int'(sb))));
      clr = pv && (!iv || m_done || ei);
      q = m_pos + (ei ? 2 : 1);
      cf = ei && fv && ((c == 5 || c == 7) || ((c == 4 || c == 6) && fw) ||
                        ((c == 4 || c == 6) && (dst == fa || dst == fb)));
      ef = clr && fv && !cf && !(blk(q, 1'b1, int'(fa)) || blk(q, 1'b1, int'(fb)));
      dn = clr && (!fv || ef);
      es = pv && !dn;
      chk(ei, ef, es, "sweep R2 R3 R4 R5 R6 R7 R9 R10");
      if (ei && (c == 1 || c == 4)) begin
        for (int k = 2; k > 0; k--) begin lp[k] = lp[k-1]; lf[k] = lf[k-1]; lr[k] = lr[k-1]; lv[k] = lv[k-1]; end
        lp[0] = m_pos + 1; lf[0] = (c == 4); lr[0] = int'(dst); lv[0] = 1'b1;
      end
      m_pos += int'(ei) + int'(ef) + int'(es && !ei && !ef);
      m_done = dn ? 1'b0 : (ei ? 1'b1 : m_done);
      es_last = es;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule